// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Switch

This block picks one of two unrelated input clocks, A and B, and passes it to its clock outputs. A change of selection never produces a runt pulse or a shortened phase. A level select input chooses the clock. The clock is passed through a gate, so the output keeps the duty cycle of whichever input is selected. Two identical copies of the selected clock leave the block. Each copy has its own active-high enable, and when that enable is low the output is released to high impedance.

Each input clock has its own lane. A lane is a small state machine clocked on the falling edge of its own clock, and it drives a registered gate enable. When the selection moves away from a running clock, that lane waits a fixed number of its own cycles and then closes its gate while the clock is low. The lane of the newly selected clock waits until it has seen, through a synchronizer, that the other gate is closed. It then counts a fixed number of its own cycles and opens its gate on a falling edge, so the first output pulse is a full high phase.

A separate clock-loss detector supplies a "dead" flag for each input. A dead clock cannot step its own state machine, so a dead flag on a deselected lane clears that lane at once, and the output drops low immediately. The same flag lets the new lane skip the wait for the other gate to close, so the switch still completes whether the dead clock stopped high or low.

The lane states are:
- IDLE: the gate is closed.
- ARM: the lane counts its own cycles before opening.
- RUN: the gate is open.
- DRAIN: the lane counts its own cycles before closing.

The transitions are:
- IDLE to ARM: the lane is selected and the other gate is seen closed or the other clock is flagged dead.
- ARM to RUN: the count has run out.
- ARM to IDLE: the selection was withdrawn.
- RUN to DRAIN: the lane is deselected.
- DRAIN to RUN: the lane is selected again.
- DRAIN to IDLE: the count has run out.
- Any state to IDLE: reset, or the lane clear from the dead flag.

Top module: `glitchless_clk_switch`

## Requirements
- R1: `sel_b_i` = 1 passes clock B and `sel_b_i` = 0 passes clock A; the output period equals the period of the chosen input.
- R2: After the select changes while both clocks run, with the change made while the old clock is high, the output passes exactly SYNC_STAGES+WAIT_CYCLES more rising edges of the old clock (5 with the defaults) and then stays low. No output high or low phase is shorter than the shorter phase of either input.
- R3: The gate enables of A and B are never both open.
- R4: After the old gate closes, at least WAIT_CYCLES rising edges of the new clock are held off before the first one is passed.
- R5: If the deselected clock is flagged dead while stopped low, the switch completes. Exactly SYNC_STAGES+WAIT_CYCLES new-clock rising edges (5) are held off, counted from a select change made while the new clock is high.
- R6: If the deselected clock is flagged dead while stopped high, the output goes low at once when the select changes. The new clock is then passed after exactly SYNC_STAGES+WAIT_CYCLES held-off rising edges (5).
- R7: `oe_i[k]` = 1 drives the selected clock on `clk_o[k]`; `oe_i[k]` = 0 releases `clk_o[k]` to high impedance, so it is never driven high, while the other output keeps running.
- R8: While `rst_n` = 0 both gates are closed and the outputs are low. After reset is released while clock A is high with `sel_b_i` = 0, A is passed after exactly SYNC_STAGES+WAIT_CYCLES held-off rising edges (5).
- R9: A gate enable changes only while its own clock is low, except by reset or the dead-flag lane clear.
- R10: The output high phase equals the high phase of the selected input (B: 8 ns high out of 26 ns in the bench).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Input clock A |
| clk_b_i | input | 1 | Input clock B |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_b_i | input | 1 | Select: 1 = clock B, 0 = clock A |
| a_dead_i | input | 1 | Clock A flagged stopped by the loss detector |
| b_dead_i | input | 1 | Clock B flagged stopped by the loss detector |
| oe_i | input | NUM_OUT | Per-output enable, 1 = drive, 0 = high impedance |
| clk_o | output | NUM_OUT | Copies of the selected clock |

## Verification
The switch is tried four ways:
- With both clocks running, in both directions. This shows that the old lane drains its fixed count before the new lane arms.
- After clock A stops low and is flagged dead. This shows that the new lane skips the wait for the dead lane's gate to close.
- After clock B stops high and is flagged dead. This tells the immediate lane clear apart from a gate that would stay stuck high.
- With one output enable low at a time. This shows that the two copies are independent.

Period and high-phase measurements tell A from B and show that the duty cycle is passed through. A monitor on every output edge flags any phase shorter than the shortest input phase.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_ARM   = 2'd1,
        LN_RUN   = 2'd2,
        LN_DRAIN = 2'd3
    } lane_state_e;

    localparam int GCS_SYNC_DEF = 2;
    localparam int GCS_WAIT_DEF = 3;
    localparam int GCS_NOUT_DEF = 2;

endpackage

// File: rtl/gcs_sync.sv
`timescale 1ns/1ps
// Falling-edge synchronizer chain; clears to 0 on reset.
module gcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gcs_lane.sv
`timescale 1ns/1ps
// One lane per input clock: decides when its own gate may open or close.
module gcs_lane
    import gcs_pkg::*;
#(
    parameter int SYNC_STAGES = GCS_SYNC_DEF,
    parameter int WAIT_CYCLES = GCS_WAIT_DEF
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic clear_i,
    input  logic want_i,
    input  logic peer_en_i,
    input  logic peer_dead_i,
    output logic gate_en_o
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    // A dead clock cannot step this lane, so its clear acts asynchronously.
    logic lane_rst_n;
    assign lane_rst_n = rst_n & ~clear_i;

    logic want_s, peer_en_s, peer_dead_s;

    gcs_sync #(.STAGES(SYNC_STAGES)) u_sync_want (
        .clk_i(clk_i), .rst_n(lane_rst_n), .d_i(want_i), .q_o(want_s));
    gcs_sync #(.STAGES(SYNC_STAGES)) u_sync_peer (
        .clk_i(clk_i), .rst_n(lane_rst_n), .d_i(peer_en_i), .q_o(peer_en_s));
    gcs_sync #(.STAGES(SYNC_STAGES)) u_sync_dead (
        .clk_i(clk_i), .rst_n(lane_rst_n), .d_i(peer_dead_i), .q_o(peer_dead_s));

    lane_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(negedge clk_i or negedge lane_rst_n) begin
        if (!lane_rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LN_IDLE: begin
                if (want_s && (!peer_en_s || peer_dead_s)) begin
                    state_d = LN_ARM;
                    cnt_d   = '0;
                end
            end
            LN_ARM: begin
                if (!want_s)             state_d = LN_IDLE;
                else if (cnt_q == LAST)  state_d = LN_RUN;
                else                     cnt_d   = cnt_q + 1'b1;
            end
            LN_RUN: begin
                if (!want_s) begin
                    state_d = LN_DRAIN;
                    cnt_d   = '0;
                end
            end
            LN_DRAIN: begin
                if (want_s)              state_d = LN_RUN;
                else if (cnt_q == LAST)  state_d = LN_IDLE;
                else                     cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // Output: the gate enable is its own flop so it never glitches on a state decode
    always_ff @(negedge clk_i or negedge lane_rst_n) begin
        if (!lane_rst_n) gate_en_o <= 1'b0;
        else             gate_en_o <= (state_d == LN_RUN) || (state_d == LN_DRAIN);
    end
endmodule

// File: rtl/gcs_outdrv.sv
`timescale 1ns/1ps
// Gating of both clocks and the per-output tri-state drivers.
module gcs_outdrv #(
    parameter int NUM_OUT = 2
) (
    input  logic               clk_a_i,
    input  logic               clk_b_i,
    input  logic               en_a_i,
    input  logic               en_b_i,
    input  logic [NUM_OUT-1:0] oe_i,
    output wire  [NUM_OUT-1:0] pad_o
);
    logic mux_clk;
    assign mux_clk = (clk_a_i & en_a_i) | (clk_b_i & en_b_i);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_pad
        assign pad_o[k] = oe_i[k] ? mux_clk : 1'bz;
    end
endmodule

// File: rtl/glitchless_clk_switch.sv
`timescale 1ns/1ps
module glitchless_clk_switch
    import gcs_pkg::*;
#(
    parameter int SYNC_STAGES = GCS_SYNC_DEF,
    parameter int WAIT_CYCLES = GCS_WAIT_DEF,
    parameter int NUM_OUT     = GCS_NOUT_DEF
) (
    input  logic               clk_a_i,
    input  logic               clk_b_i,
    input  logic               rst_n,
    input  logic               sel_b_i,
    input  logic               a_dead_i,
    input  logic               b_dead_i,
    input  logic [NUM_OUT-1:0] oe_i,
    output wire  [NUM_OUT-1:0] clk_o
);
    localparam int NLANE = 2;

    logic [NLANE-1:0] lane_clk, lane_want, lane_dead, lane_clear, lane_en;
    logic en_a, en_b;

    assign lane_clk  = {clk_b_i, clk_a_i};
    assign lane_want = {sel_b_i, ~sel_b_i};
    assign lane_dead = {b_dead_i, a_dead_i};

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lane_clear[i] = lane_dead[i] & ~lane_want[i];

        gcs_lane #(
            .SYNC_STAGES(SYNC_STAGES),
            .WAIT_CYCLES(WAIT_CYCLES)
        ) u_lane (
            .clk_i      (lane_clk[i]),
            .rst_n      (rst_n),
            .clear_i    (lane_clear[i]),
            .want_i     (lane_want[i]),
            .peer_en_i  (lane_en[NLANE-1-i]),
            .peer_dead_i(lane_dead[NLANE-1-i]),
            .gate_en_o  (lane_en[i])
        );
    end

    assign en_a = lane_en[0];
    assign en_b = lane_en[1];

    gcs_outdrv #(.NUM_OUT(NUM_OUT)) u_outdrv (
        .clk_a_i(clk_a_i),
        .clk_b_i(clk_b_i),
        .en_a_i (en_a),
        .en_b_i (en_b),
        .oe_i   (oe_i),
        .pad_o  (clk_o)
    );
endmodule

// File: rtl/glitchless_clk_switch_chk.sv
`timescale 1ns/1ps
module glitchless_clk_switch_chk (
    input logic clk_a_i,
    input logic clk_b_i,
    input logic rst_n,
    input logic sel_b_i,
    input logic a_dead_i,
    input logic b_dead_i,
    input logic en_a,
    input logic en_b
);
    AST_NO_OVERLAP_A: assert property (@(posedge clk_a_i) disable iff (!rst_n) !(en_a && en_b)); // R3
    AST_NO_OVERLAP_B: assert property (@(posedge clk_b_i) disable iff (!rst_n) !(en_a && en_b)); // R3
    AST_CLOSED_AFTER_RESET: assert property (@(posedge clk_a_i) disable iff (!rst_n) $rose(rst_n) |-> (!en_a && !en_b)); // R8
    AST_DEAD_A_CLOSED: assert property (@(posedge clk_b_i) disable iff (!rst_n) (a_dead_i && sel_b_i) |-> !en_a); // R6
    AST_DEAD_B_CLOSED: assert property (@(posedge clk_a_i) disable iff (!rst_n) (b_dead_i && !sel_b_i) |-> !en_b); // R6

    always @(en_a) begin
        if (rst_n && !(a_dead_i && sel_b_i))
            AST_GATE_A_MOVES_LOW: assert (!clk_a_i); // R9
    end
    always @(en_b) begin
        if (rst_n && !(b_dead_i && !sel_b_i))
            AST_GATE_B_MOVES_LOW: assert (!clk_b_i); // R9
    end
endmodule

bind glitchless_clk_switch glitchless_clk_switch_chk u_chk (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .rst_n   (rst_n),
    .sel_b_i (sel_b_i),
    .a_dead_i(a_dead_i),
    .b_dead_i(b_dead_i),
    .en_a    (en_a),
    .en_b    (en_b)
);

// File: tb/glitchless_clk_switch_tb.sv
`timescale 1ns/1ps
module glitchless_clk_switch_tb;
    localparam realtime A_HI = 10, A_LO = 10;   // 50 MHz clock A
    localparam realtime B_HI = 8,  B_LO = 18;
    localparam realtime MIN_PHASE = 8;
    localparam int HOLD = 5;                    // sync stages + wait cycles

    logic clk_a = 0, clk_b = 0, rst_n = 0, sel_b = 0, a_dead = 0, b_dead = 0;
    logic [1:0] oe = 2'b11;
    logic run_a = 1, run_b = 1, park_a = 0, park_b = 0;
    wire  [1:0] clk_o;
    wire        out0;
    assign out0 = clk_o[0];

    int n_chk = 0, n_bad = 0, n_glitch = 0;
    bit mon_on = 0;
    realtime last_edge = 0;

    glitchless_clk_switch u_dut (
        .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_n(rst_n), .sel_b_i(sel_b),
        .a_dead_i(a_dead), .b_dead_i(b_dead), .oe_i(oe), .clk_o(clk_o));

    always begin
        if (run_a) begin clk_a = 1; #(A_HI); clk_a = 0; #(A_LO); end
        else begin clk_a = park_a; #1; end
    end
    always begin
        if (run_b) begin clk_b = 1; #(B_HI); clk_b = 0; #(B_LO); end
        else begin clk_b = park_b; #1; end
    end

    // Phase monitor on every output edge (R2)
    always @(out0) begin
        if (mon_on) begin
            if (last_edge > 0 && ($realtime - last_edge) < MIN_PHASE - 0.01) n_glitch++;
            last_edge = $realtime;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pos(input bit use_b);
        if (use_b) @(posedge clk_b); else @(posedge clk_a);
    endtask

    task automatic count_pass(input bit use_b, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            wait_pos(use_b); #1;
            if (out0 === 1'b1) n++; else break;
        end
    endtask

    task automatic count_gap(input bit use_b, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            wait_pos(use_b); #1;
            if (out0 === 1'b1) break;
            n++;
        end
    endtask

    task automatic period(output int p);
        realtime t0;
        @(posedge out0); t0 = $realtime;
        @(posedge out0); p = int'($realtime - t0);
    endtask

    task automatic high_phase(output int h);
        realtime t0;
        @(posedge out0); t0 = $realtime;
        @(negedge out0); h = int'($realtime - t0);
    endtask

    task automatic t_reset;
        int g;
        #50;
        chk(out0 === 1'b0, "R8", "output low in reset", int'(out0), 0);
        @(posedge clk_a); #1; rst_n = 1; mon_on = 1;
        count_gap(1'b0, g);
        chk(g == HOLD, "R8", "held-off A edges after reset", g, HOLD);
    endtask

    task automatic t_select_a;
        int p;
        period(p);
        chk(p == 20, "R1", "period with select low", p, 20);
    endtask

    task automatic t_run_switch(input bit to_b);
        int p, g;
        wait_pos(!to_b); #1; sel_b = to_b;
        count_pass(!to_b, p);
        chk(p == HOLD, "R2", "old-clock pulses after select change", p, HOLD);
        count_gap(to_b, g);
        chk(g >= 3 && g <= 9, "R4", "held-off new edges after close", g, 3);
    endtask

    task automatic t_on_b;
        int p, h;
        period(p);
        chk(p == 26, "R1", "period with select high", p, 26);
        high_phase(h);
        chk(h == 8, "R10", "high phase follows B", h, 8);
    endtask

    task automatic t_oe;
        bit hi0, hi1;
        mon_on = 0;
        oe = 2'b10; hi0 = 0; hi1 = 0;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (clk_o[0] === 1'b1) hi0 = 1;
            if (clk_o[1] === 1'b1) hi1 = 1;
        end
        chk(!hi0 && hi1, "R7", "output 0 disabled, output 1 running", int'({hi0, hi1}), 1);
        oe = 2'b01; hi0 = 0; hi1 = 0;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (clk_o[0] === 1'b1) hi0 = 1;
            if (clk_o[1] === 1'b1) hi1 = 1;
        end
        chk(hi0 && !hi1, "R7", "output 1 disabled, output 0 running", int'({hi0, hi1}), 2);
        oe = 2'b11;
        #50; last_edge = 0; mon_on = 1;
    endtask

    task automatic t_stop_low;
        int g;
        @(negedge clk_a); run_a = 0; park_a = 0;
        #100; a_dead = 1; #100;
        @(posedge clk_b); #1; sel_b = 1;
        count_gap(1'b1, g);
        chk(g == HOLD, "R5", "held-off B edges, A dead low", g, HOLD);
        a_dead = 0; run_a = 1; #200;
    endtask

    task automatic t_stop_high;
        int g;
        @(posedge clk_b); run_b = 0; park_b = 1;
        #100;
        chk(out0 === 1'b1, "R6", "output holds stopped-high B", int'(out0), 1);
        b_dead = 1; #100;
        @(posedge clk_a); #1; sel_b = 0; #1;
        chk(out0 === 1'b0, "R6", "output low at once on select", int'(out0), 0);
        count_gap(1'b0, g);
        chk(g == HOLD, "R6", "held-off A edges, B dead high", g, HOLD);
        b_dead = 0; run_b = 1; #200;
    endtask

    initial begin
        t_reset();
        #100;
        t_select_a();
        t_run_switch(1'b1);
        t_on_b();
        t_run_switch(1'b0);
        #100;
        t_oe();
        t_stop_low();
        t_stop_high();
        chk(n_glitch == 0, "R2", "short output phases", n_glitch, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule